// File: doc/BRIEF.md
# Fan PWM Generator with Register Port

This block drives one pulse-width-modulated output for a two-wire fan. Software sets it up through a small word-wide register port. The port has a control word and a speed-limit word. The control word holds a run bit, a wiring-mode bit and an 8-bit duty setting. The speed-limit word holds a 16-bit maximum-RPM value. Software reads that value back, but it does not shape the output.

The output period does not change. It lasts 40 ms of the system clock, and the clock frequency is a parameter. When the duty setting is D, the output is high for the first floor(D × P / 255) cycles of each period, where P is the period length in cycles. The polarity is always active-high. Clearing the run bit forces the output low at once and drops the position within the period. Setting the run bit again starts a new period from its beginning. A new duty setting takes effect at the next period boundary. Every period after that boundary follows the new value exactly.

Top module: `fan_pwm_top`

## Requirements
- R1: After reset, the control word at offset 0x0 reads 0 and the word at offset 0x4 reads 4000 (0x00000FA0). The output is low.
- R2: In the control word at byte offset 0x0, bit 0 is the run bit (1 = running), bit 1 is the wiring-mode bit (0 = two-wire), and bits 23:16 are the duty setting. All other bits read 0, so writing 0xFFFFFFFF reads back as 0x00FF0003.
- R3: The word at byte offset 0x4 holds the maximum-RPM value in bits 15:0. Writing 0xFFFFFFFF reads back as 0x0000FFFF.
- R4: A write to any byte address other than 0x0 and 0x4 changes no register. A read from such an address returns 0.
- R5: While running, the output repeats with a period of P = CLK_HZ × 40 / 1000 clock cycles. In each period it is high for floor(D × P / 255) cycles, and those cycles come at the start of the period.
- R6: A duty setting of 0 keeps the output low for the whole period. A duty setting of 255 keeps it high for the whole period.
- R7: When the run bit is 0, the output is low. This starts in the clock cycle after the write that clears the run bit, and it holds whatever duty is written meanwhile.
- R8: A write that sets the run bit starts a new period. The output is high in the cycle that follows the first clock edge after the write, provided D > 0.
- R9: After the duty setting changes, the first period may show the old value. Every period from the second one onward is high for exactly floor(Dnew × P / 255) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| pwm_o | output | 1 | Fan drive output, active-high |

## Verification
Suppose the period counter is corrupt, for example it skips its terminal count or leaves a stale position after a disable. The high-cycle count of the next full period then differs from floor(D × P / 255), and the bench sees this within one period. A threshold that is latched late or never latched shows up as a wrong count in the second period after a duty change. A fault in the register file shows up as a wrong read-back in the same cycle, because the read path is combinational.

// File: rtl/fan_pwm_pkg.sv
// Package: fan_pwm_pkg
// Shared constants and the control-word layout for the fan PWM block.
// Assumes byte addressing with 32-bit words spaced four bytes apart.
package fan_pwm_pkg;
    localparam int WORD_W   = 32;
    localparam int DUTY_W   = 8;
    localparam int RPM_W    = 16;
    localparam int DUTY_MAX = (1 << DUTY_W) - 1;

    localparam int OFS_CTRL = 0;
    localparam int OFS_RPM  = 4;

    localparam int BIT_RUN  = 0;
    localparam int BIT_MODE = 1;
    localparam int DUTY_LSB = 16;

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
        logic              mode;
        logic              run;
    } ctrl_t;
endpackage

// File: rtl/fan_pwm_regs.sv
// Module: fan_pwm_regs
// Register file: the control word and the maximum-RPM word.
// Writes use a single-cycle strobe. Reads are combinational.
// Unmapped addresses ignore writes and read as zero.
module fan_pwm_regs
    import fan_pwm_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int RPM_RESET = 4000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata,
    output ctrl_t               ctrl_o,
    output logic [RPM_W-1:0]    rpm_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_RPM  = ADDR_W'(OFS_RPM);

    ctrl_t            ctrl_q;
    logic [RPM_W-1:0] rpm_q;
    logic             hit_ctrl;
    logic             hit_rpm;

    // Address decode for the two mapped words.
    assign hit_ctrl = (addr == A_CTRL);
    assign hit_rpm  = (addr == A_RPM);

    // Register update on a strobed write to a mapped word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rpm_q  <= RPM_W'(RPM_RESET);
        end else if (wr_en) begin
            if (hit_ctrl) begin
                ctrl_q.run  <= wdata[BIT_RUN];
                ctrl_q.mode <= wdata[BIT_MODE];
                ctrl_q.duty <= wdata[DUTY_LSB +: DUTY_W];
            end
            if (hit_rpm) begin
                rpm_q <= wdata[RPM_W-1:0];
            end
        end
    end

    // Read multiplexer; unused bits and unmapped addresses give zero.
    always_comb begin
        rdata = '0;
        if (hit_ctrl) begin
            rdata[BIT_RUN]               = ctrl_q.run;
            rdata[BIT_MODE]              = ctrl_q.mode;
            rdata[DUTY_LSB +: DUTY_W]    = ctrl_q.duty;
        end else if (hit_rpm) begin
            rdata[RPM_W-1:0] = rpm_q;
        end
    end

    assign ctrl_o = ctrl_q;
    assign rpm_o  = rpm_q;
endmodule

// File: rtl/fan_pwm_thresh.sv
// Module: fan_pwm_thresh
// Scales the duty setting onto the period: thr = floor(duty * PERIOD_CYC / 255).
// Purely combinational, and division by a constant only.
module fan_pwm_thresh
    import fan_pwm_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int PERIOD_CYC = 255
) (
    input  logic [DUTY_W-1:0] duty_i,
    output logic [CNT_W-1:0]  thr_o
);
    localparam int PW = CNT_W + DUTY_W;
    localparam logic [PW-1:0] PER_V = PW'(PERIOD_CYC);
    localparam logic [PW-1:0] DIV_V = PW'(DUTY_MAX);

    logic [PW-1:0] prod;
    logic [PW-1:0] quot;

    // Product and quotient; the quotient never exceeds PERIOD_CYC.
    always_comb begin
        prod  = PW'(duty_i) * PER_V;
        quot  = prod / DIV_V;
        thr_o = quot[CNT_W-1:0];
    end
endmodule

// File: rtl/fan_pwm_core.sv
// Module: fan_pwm_core
// Period counter and duty compare.
// Assumes run_i comes from a register. The threshold is latched when a
// period starts, so a duty change takes effect at the next boundary.
module fan_pwm_core #(
    parameter int CNT_W      = 8,
    parameter int PERIOD_CYC = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             pwm_o,
    output logic             act_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] thr_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

    logic             act_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] thr_q;

    // Period position, and the threshold latched at each period start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt_q <= '0;
            thr_q <= '0;
        end else if (!run_i) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (!act_q || cnt_q == LAST) begin
            act_q <= 1'b1;
            cnt_q <= '0;
            thr_q <= thr_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Active-high compare, gated by the run bit.
    assign pwm_o = run_i && act_q && (cnt_q < thr_q);
    assign act_o = act_q;
    assign cnt_o = cnt_q;
    assign thr_o = thr_q;
endmodule

// File: rtl/fan_pwm_top.sv
// Module: fan_pwm_top
// Single-channel fan PWM with a register port and a fixed 40 ms period.
// Assumes CLK_HZ * 40 / 1000 >= 1. The mode and max-RPM fields are stored
// for software but do not shape the output.
module fan_pwm_top
    import fan_pwm_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int PERIOD_MS = 40,
    parameter int ADDR_W    = 8,
    parameter int RPM_RESET = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              pwm_o
);
    localparam longint PERIOD_L   = (longint'(CLK_HZ) * PERIOD_MS) / 1000;
    localparam int     PERIOD_CYC = int'(PERIOD_L);
    localparam int     CNT_W      = $clog2(PERIOD_CYC + 1);

    ctrl_t            ctrl_w;
    logic [RPM_W-1:0] rpm_w;
    logic [CNT_W-1:0] thr_live_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] thr_w;
    logic             act_w;

    fan_pwm_regs #(.ADDR_W(ADDR_W), .RPM_RESET(RPM_RESET)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ctrl_o(ctrl_w), .rpm_o(rpm_w)
    );

    fan_pwm_thresh #(.CNT_W(CNT_W), .PERIOD_CYC(PERIOD_CYC)) i_thresh (
        .duty_i(ctrl_w.duty), .thr_o(thr_live_w)
    );

    fan_pwm_core #(.CNT_W(CNT_W), .PERIOD_CYC(PERIOD_CYC)) i_core (
        .clk(clk), .rst_n(rst_n), .run_i(ctrl_w.run), .thr_i(thr_live_w),
        .pwm_o(pwm_o), .act_o(act_w), .cnt_o(cnt_w), .thr_o(thr_w)
    );
endmodule

// File: rtl/fan_pwm_checker.sv
// Module: fan_pwm_checker
// Assertions on the fan PWM top, attached with a bind.
module fan_pwm_checker #(
    parameter int ADDR_W     = 8,
    parameter int CNT_W      = 8,
    parameter int PERIOD_CYC = 255,
    parameter int RPM_RESET  = 4000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              pwm_o,
    input logic              run,
    input logic [15:0]       rpm,
    input logic              act,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  thr
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(PERIOD_CYC);

    AST_RESET_VALUES: assert property (@(posedge clk)
        !rst_n |=> (rpm == 16'(RPM_RESET) && !run && !pwm_o));            // R1
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != ADDR_W'(0) && addr != ADDR_W'(4)) |-> rdata == 32'd0);   // R4
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);                                                     // R5
    AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act && cnt == LAST && wr_en == 1'b0) |=> (cnt == 0 && act)); // R5
    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act && thr == FULL) |-> pwm_o);                           // R6
    AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0) && !wdata[0]) |=> !pwm_o);           // R7
    AST_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act) |-> cnt == 0);                                         // R8
endmodule

bind fan_pwm_top fan_pwm_checker #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PERIOD_CYC(PERIOD_CYC), .RPM_RESET(RPM_RESET)
) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwm_o(pwm_o), .run(ctrl_w.run), .rpm(rpm_w),
    .act(act_w), .cnt(cnt_w), .thr(thr_w)
);

// File: tb/test_fan_pwm_top.sv
// Directed bench for fan_pwm_top. CLK_HZ is scaled so that one period is 255 cycles.
module test_fan_pwm_top;
    localparam int CLK_HZ = 6375;
    localparam int PER    = (CLK_HZ * 40) / 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwm_o;
    int          n_run = 0;
    int          n_fail = 0;

    fan_pwm_top #(.CLK_HZ(CLK_HZ)) i_fan_pwm_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h00;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
        addr = 8'h00;
    endtask

    function automatic int expect_hi(input int d);
        return (d * PER) / 255;
    endfunction

    task automatic count_hi(output int hi);
        hi = 0;
        for (int i = 0; i < PER; i++) begin
            hi += int'(pwm_o);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); check("R1 ctrl", v, 0);
        rd(8'h04, v); check("R1 rpm", v, 32'h0FA0);
        check("R1 pwm", pwm_o, 0);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        wr(8'h00, 32'hFFFF_FFFE); rd(8'h00, v); check("R2 mask", v, 32'h00FF_0002);
        wr(8'h00, 32'h0000_0002); rd(8'h00, v); check("R2 mode", v, 32'h0000_0002);
        wr(8'h00, 32'h0000_0000);
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); check("R3 rpm", v, 32'h0000_FFFF);
        wr(8'h04, 32'h0000_1234); rd(8'h04, v); check("R3 rpm2", v, 32'h0000_1234);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(8'h08, 32'hFFFF_FFFF); wr(8'h02, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h08, v); check("R4 read", v, 0);
        rd(8'h00, v); check("R4 ctrl kept", v, 0);
        rd(8'h04, v); check("R4 rpm kept", v, 32'h0000_1234);
        check("R4 pwm", pwm_o, 0);
    endtask

    task automatic t_duty(input int d);
        int hi;
        wr(8'h00, {8'h00, 8'(d), 16'h0001});
        @(negedge clk);
        check("R8 first", pwm_o, (d > 0) ? 1 : 0);
        count_hi(hi);
        check("R5 period1", hi, expect_hi(d));
        count_hi(hi);
        check((d == 0 || d == 255) ? "R6 extreme" : "R5 period2", hi, expect_hi(d));
        wr(8'h00, 32'h0);
    endtask

    task automatic t_stop();
        int hi;
        wr(8'h00, 32'h00FF_0001);
        repeat (40) @(negedge clk);
        wr(8'h00, 32'h00FF_0000);
        check("R7 immediate", pwm_o, 0);
        count_hi(hi);
        check("R7 held", hi, 0);
    endtask

    task automatic t_restart();
        int hi;
        wr(8'h00, {8'h00, 8'd100, 16'h0001});
        repeat (77) @(negedge clk);
        wr(8'h00, 32'h0);
        wr(8'h00, {8'h00, 8'd100, 16'h0001});
        @(negedge clk);
        check("R8 restart", pwm_o, 1);
        count_hi(hi);
        check("R8 fresh period", hi, expect_hi(100));
        wr(8'h00, 32'h0);
    endtask

    task automatic t_change(input int d0, input int d1);
        int hi;
        logic prev;
        wr(8'h00, {8'h00, 8'(d0), 16'h0001});
        repeat (PER + 90) @(negedge clk);
        wr(8'h00, {8'h00, 8'(d1), 16'h0001});
        repeat (PER + 5) @(negedge clk);
        prev = pwm_o;
        for (int i = 0; i < 2 * PER; i++) begin
            @(negedge clk);
            if (pwm_o && !prev) break;
            prev = pwm_o;
        end
        count_hi(hi);
        check("R9 second period", hi, expect_hi(d1));
        count_hi(hi);
        check("R9 third period", hi, expect_hi(d1));
        wr(8'h00, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_unmapped();
        t_duty(1);
        t_duty(64);
        t_duty(128);
        t_duty(254);
        t_duty(0);
        t_duty(255);
        t_stop();
        t_restart();
        t_change(50, 180);
        t_change(200, 30);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule